// File: doc/BRIEF.md
# Justified Audio Serializer

This block turns 16-bit stereo PCM sample pairs into a single serial data line for an audio DAC. Each frame has a left slot followed by a right slot. Each slot is 16 or 32 bit periods long. A 5-bit justification offset sets where the most significant bit of the sample lands inside its slot. Offset 0 gives MSB-aligned output, offset 1 gives the I2S layout, and offset 16 in a 32-bit slot places the sample at the end of the slot. Every slot position the sample does not occupy carries a zero.

An external clock generator supplies two strobes. The first is a one-cycle bit strobe for each bit period, aligned with the falling edge of the bit clock. The second is a frame strobe, which comes with the bit strobe that opens a left slot. A new sample pair is taken from a valid/ready handshake only at that moment. The pair is held in one holding register for the whole frame. When no pair is offered at a frame start, the block raises its no-data flag and keeps the line low for the frame.

Top module: `pcm_slot_serializer`

## Requirements
- R1: After reset, `sdata` is 0 and `no_data` is 1. While `bit_stb` is low, `pair_ready` is 0.
- R2: `pair_ready` is 1 exactly in cycles where `bit_stb` and `frame_stb` are both 1. A pair offered on `pair_valid` in any other cycle is ignored and does not change the serial output.
- R3: With `just_ofs` = 0, the sample MSB appears on `sdata` in slot bit 0, and the following bits follow in descending bit order.
- R4: With `just_ofs` = 1, slot bit 0 is 0 and the sample MSB appears in slot bit 1 (I2S layout).
- R5: With `slot_wide` = 1 (32-bit slot) and `just_ofs` = 16, the sample LSB appears in slot bit 31.
- R6: Every slot bit outside the 16 sample bits is driven to 0.
- R7: The effective offset is min(`just_ofs`, slot length − 16). With `slot_wide` = 0 (16-bit slot) the offset is always 0, and with `slot_wide` = 1 any value above 16 acts as 16.
- R8: In each frame the left slot is sent first, taken from `left_in`. The right slot follows, taken from `right_in`. Both come from the pair accepted at that frame start.
- R9: If `pair_valid` is 0 at a frame start, `no_data` is 1 and `sdata` is 0 for every bit of that frame.
- R10: `sdata` and `no_data` change only in the cycle after a `bit_stb` pulse and hold their values between pulses.
- R11: If the last bit period of a frame passes without a new `frame_stb`, the next `bit_stb` sets `no_data` to 1 and `sdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | A stereo pair is offered |
| pair_ready | output | 1 | Pair accepted this cycle (frame start) |
| left_in | input | 16 | Left channel sample |
| right_in | input | 16 | Right channel sample |
| bit_stb | input | 1 | One-cycle pulse per bit period (bit clock falling edge) |
| frame_stb | input | 1 | With `bit_stb`, marks the first bit of a left slot |
| slot_wide | input | 1 | 0: 16-bit slots, 1: 32-bit slots |
| just_ofs | input | 5 | Justification offset of the sample MSB within the slot |
| sdata | output | 1 | Serial data to the DAC |
| no_data | output | 1 | No sample pair is active in the current frame |

## Verification
The bench builds the block with its default 16-bit sample width. That width gives one power-of-two slice path, a 6-bit frame counter and 5-bit offsets, so the clamp range and the full 64-bit frame can both be reached. Frames alternate between narrow and wide slots and sweep offsets 0, 1, 16 and values past the clamp limit. Bogus pairs are offered in the middle of frames. A frame with no pair and a run of strobes without a frame start show the quiet states.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef enum logic {
      SLOT_NARROW = 1'b0,
      SLOT_WIDE   = 1'b1
   } slot_mode_e;
endpackage

// File: rtl/pss_slot_track.sv
module pss_slot_track
   import pss_pkg::*;
#(
   parameter int unsigned SMP_W = 16,
   parameter int unsigned CNT_W = $clog2(4 * SMP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             frame_stb,
   input  logic             pair_valid,
   input  logic [SMP_W-1:0] left_in,
   input  logic [SMP_W-1:0] right_in,
   input  slot_mode_e       slot_mode,
   output logic [CNT_W-1:0] nxt_cnt,
   output logic             nxt_active,
   output logic [SMP_W-1:0] nxt_left,
   output logic [SMP_W-1:0] nxt_right,
   output logic             active_q
);
   localparam logic [CNT_W-1:0] LAST_N = CNT_W'(2 * SMP_W - 1);
   localparam logic [CNT_W-1:0] LAST_W = CNT_W'(4 * SMP_W - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [SMP_W-1:0] left_q, right_q;
   logic [CNT_W-1:0] last_bit;
   logic             at_end;

   assign last_bit = (slot_mode == SLOT_WIDE) ? LAST_W : LAST_N;
   assign at_end   = (cnt_q >= last_bit);

   always_comb begin
      nxt_cnt    = cnt_q;
      nxt_active = active_q;
      nxt_left   = left_q;
      nxt_right  = right_q;
      if (bit_stb) begin
         if (frame_stb) begin
            nxt_cnt    = '0;
            nxt_active = pair_valid;
            if (pair_valid) begin
               nxt_left  = left_in;
               nxt_right = right_in;
            end
         end else if (at_end) begin
            nxt_cnt    = '0;
            nxt_active = 1'b0;
         end else begin
            nxt_cnt = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         left_q   <= '0;
         right_q  <= '0;
      end else begin
         cnt_q    <= nxt_cnt;
         active_q <= nxt_active;
         left_q   <= nxt_left;
         right_q  <= nxt_right;
      end
   end

   // R2: holding register loads only at a frame-start strobe
   a_r2_hold_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_stb && frame_stb) |=> ($stable(left_q) && $stable(right_q)));

   // R2: a frame becomes active only through an accepted pair
   a_r2_active_from_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && frame_stb && !pair_valid) |=> !active_q);

   // R11: frame that runs out without a new start goes quiet
   a_r11_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !frame_stb && at_end) |=> !active_q);
endmodule

// File: rtl/pss_bit_pick.sv
module pss_bit_pick
   import pss_pkg::*;
#(
   parameter int unsigned SMP_W = 16,
   parameter int unsigned CNT_W = $clog2(4 * SMP_W),
   parameter int unsigned OFS_W = $clog2(2 * SMP_W)
) (
   input  logic [CNT_W-1:0] cnt,
   input  slot_mode_e       slot_mode,
   input  logic [OFS_W-1:0] just,
   input  logic [SMP_W-1:0] left_smp,
   input  logic [SMP_W-1:0] right_smp,
   output logic             bit_o
);
   localparam logic [CNT_W-1:0] LEN_N = CNT_W'(SMP_W);
   localparam logic [CNT_W-1:0] LEN_W = CNT_W'(2 * SMP_W);
   localparam logic [CNT_W-1:0] SMP_V = CNT_W'(SMP_W);
   localparam bit               POW2  = ((SMP_W & (SMP_W - 1)) == 0);

   logic [CNT_W-1:0] len_v, room_v, just_v, eff_v, pos_v, rel_v;
   logic             right_ch, in_win;
   logic [SMP_W-1:0] smp, sh;

   assign len_v  = (slot_mode == SLOT_WIDE) ? LEN_W : LEN_N;
   assign room_v = len_v - SMP_V;
   assign just_v = CNT_W'(just);
   assign eff_v  = (just_v > room_v) ? room_v : just_v;

   generate
      if (POW2) begin : g_slice
         localparam int unsigned LN = $clog2(SMP_W);
         always_comb begin
            if (slot_mode == SLOT_WIDE) begin
               right_ch = cnt[LN+1];
               pos_v    = CNT_W'(cnt[LN:0]);
            end else begin
               right_ch = cnt[LN];
               pos_v    = CNT_W'(cnt[LN-1:0]);
            end
         end
      end else begin : g_arith
         always_comb begin
            right_ch = (cnt >= len_v);
            pos_v    = right_ch ? (cnt - len_v) : cnt;
         end
      end
   endgenerate

   always_comb begin
      smp    = right_ch ? right_smp : left_smp;
      in_win = (pos_v >= eff_v) && (pos_v < eff_v + SMP_V);
      rel_v  = pos_v - eff_v;
      sh     = smp << rel_v;
      bit_o  = in_win & sh[SMP_W-1];
   end

   // R7: clamped offset keeps the sample LSB inside the slot
   always_comb begin
      a_r7_lsb_inside: assert (eff_v + SMP_V <= len_v);
   end
endmodule

// File: rtl/pcm_slot_serializer.sv
module pcm_slot_serializer
   import pss_pkg::*;
#(
   parameter int unsigned SMP_W = 16,
   parameter int unsigned OFS_W = $clog2(2 * SMP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pair_valid,
   output logic             pair_ready,
   input  logic [SMP_W-1:0] left_in,
   input  logic [SMP_W-1:0] right_in,
   input  logic             bit_stb,
   input  logic             frame_stb,
   input  logic             slot_wide,
   input  logic [OFS_W-1:0] just_ofs,
   output logic             sdata,
   output logic             no_data
);
   localparam int unsigned CNT_W = $clog2(4 * SMP_W);

   generate
      if (SMP_W < 2) begin : g_bad_width
         $error("SMP_W must be at least 2");
      end
      if (OFS_W < $clog2(2 * SMP_W)) begin : g_bad_ofs
         $error("OFS_W too narrow for a wide slot");
      end
   endgenerate

   slot_mode_e       mode;
   logic [CNT_W-1:0] nxt_cnt;
   logic             nxt_active, active_q, pick;
   logic [SMP_W-1:0] nxt_left, nxt_right;

   assign mode       = slot_mode_e'(slot_wide);
   assign pair_ready = bit_stb & frame_stb;
   assign no_data    = ~active_q;

   pss_slot_track #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .frame_stb  (frame_stb),
      .pair_valid (pair_valid),
      .left_in    (left_in),
      .right_in   (right_in),
      .slot_mode  (mode),
      .nxt_cnt    (nxt_cnt),
      .nxt_active (nxt_active),
      .nxt_left   (nxt_left),
      .nxt_right  (nxt_right),
      .active_q   (active_q)
   );

   pss_bit_pick #(.SMP_W(SMP_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_pick (
      .cnt       (nxt_cnt),
      .slot_mode (mode),
      .just      (just_ofs),
      .left_smp  (nxt_left),
      .right_smp (nxt_right),
      .bit_o     (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       sdata <= 1'b0;
      else if (bit_stb) sdata <= nxt_active & pick;
   end

   // R10: serial line moves only after a bit strobe
   a_r10_sdata_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(sdata));

   // R10: no-data flag moves only after a bit strobe
   a_r10_flag_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(no_data));

   // R9: line is low whenever no pair is active
   a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      no_data |-> !sdata);
endmodule

// File: tb/tb_pcm_slot_serializer.sv
module tb_pcm_slot_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pair_valid = 1'b0;
   logic        pair_ready;
   logic [15:0] left_in = '0, right_in = '0;
   logic        bit_stb = 1'b0, frame_stb = 1'b0, slot_wide = 1'b0;
   logic [4:0]  just_ofs = '0;
   logic        sdata, no_data;

   int n_cmp = 0, n_bad = 0;
   logic [1:0] expq[$];   // {no_data, sdata}
   logic       stb_d = 1'b0;
   logic       done = 1'b0;

   always #2 clk = ~clk;

   pcm_slot_serializer dut (
      .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
      .left_in(left_in), .right_in(right_in), .bit_stb(bit_stb), .frame_stb(frame_stb),
      .slot_wide(slot_wide), .just_ofs(just_ofs), .sdata(sdata), .no_data(no_data));

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_bit(logic [15:0] l, logic [15:0] r, logic wide,
                                    int just, int b);
      int len = wide ? 32 : 16;
      int e   = (just > len - 16) ? len - 16 : just;
      int p   = b % len;
      logic [15:0] s = (b >= len) ? r : l;
      if (p >= e && p < e + 16) return s[15 - (p - e)];
      return 1'b0;
   endfunction

   // monitor: one compare per bit strobe, half a cycle after the update
   always @(posedge clk) stb_d <= bit_stb;
   always @(negedge clk) begin
      if (stb_d) begin
         if (expq.size() == 0) check("R10 unexpected update", 16'(sdata), 16'h0);
         else begin
            logic [1:0] e;
            e = expq.pop_front();
            check("R3-R9 sdata", 16'(sdata), 16'(e[0]));
            check("R9 no_data", 16'(no_data), 16'(e[1]));
         end
      end
   end

   task automatic one_bit(logic first, logic valid, logic [15:0] l, logic [15:0] r,
                          logic [1:0] expv);
      @(negedge clk);
      frame_stb  = first;
      pair_valid = valid;
      left_in    = l;
      right_in   = r;
      expq.push_back(expv);
      bit_stb    = 1'b1;
      #1;
      check(first ? "R2 ready at frame start" : "R2 ready mid frame",
            16'(pair_ready), 16'(first));
      @(negedge clk);
      bit_stb = 1'b0; frame_stb = 1'b0; pair_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R10 sdata held between strobes", 16'(sdata), 16'(expv[0]));
   endtask

   task automatic run_frame(logic valid, logic [15:0] l, logic [15:0] r,
                            logic wide, int just);
      int nb = wide ? 64 : 32;
      slot_wide = wide;
      just_ofs  = 5'(just);
      for (int b = 0; b < nb; b++) begin
         logic [1:0] ev;
         ev = valid ? {1'b0, exp_bit(l, r, wide, just, b)} : 2'b10;
         if (b == 0) one_bit(1'b1, valid, l, r, ev);
         else        one_bit(1'b0, 1'b1, ~l, ~r, ev);  // R2: offers ignored
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 sdata after reset", 16'(sdata), 16'h0);
      check("R1 no_data after reset", 16'(no_data), 16'h1);
      check("R1 ready idle", 16'(pair_ready), 16'h0);

      run_frame(1'b1, 16'hA35C, 16'h1E87, 1'b0, 0);   // R3 R8 narrow
      run_frame(1'b1, 16'h8001, 16'h7FFE, 1'b1, 0);   // R3 R6 wide MSB
      run_frame(1'b1, 16'hC3A5, 16'h5A3C, 1'b1, 1);   // R4 I2S
      run_frame(1'b1, 16'h0F01, 16'hF0F1, 1'b1, 16);  // R5 R6 LSB-justified
      run_frame(1'b1, 16'h9669, 16'h2BD4, 1'b1, 27);  // R7 clamp wide
      run_frame(1'b1, 16'h4C71, 16'hE38E, 1'b0, 3);   // R7 narrow forces 0
      run_frame(1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 0);   // R9 no pair
      run_frame(1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 5);   // R7 R8 narrow all ones
      // R11: strobes continue past the frame without a frame start
      for (int k = 0; k < 6; k++) one_bit(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 2'b10);
      repeat (4) @(negedge clk);
      check("R11 quiet line", 16'(sdata), 16'h0);
      check("R11 no_data", 16'(no_data), 16'h1);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule